// File: doc/BRIEF.md
# Shift-Rotate Unit With Flags

This block performs one 64-bit single-operand shift or rotate per accepted cycle and produces the status flags that the operation defines. Seven operations are available: rotate left and right, rotate left and right through the carry bit, logical shift left and right, and arithmetic shift right. Each operation follows its own carry, overflow and partial-update rules, so the block is more than a plain barrel shifter. The two carry rotates treat the incoming carry and the operand as one 65-bit ring.

The shift amount comes from one of three places, chosen by a select input: an immediate value, a register value, or a fixed amount of one. Only the low six bits of the chosen source are used. Results are registered. A write enable and a flag-update mask tell the surrounding datapath whether to commit the result and which flags to take. Decode, the register file and memory read-modify-write sit outside this block.

Top module: `shrot_unit`

## Requirements
- R1: `count_src` picks the shift amount n: 0 selects `imm_count`, 1 selects `reg_count`, and 2 or 3 selects a fixed amount of one. Only bits 5:0 of the selected source form n.
- R2: When n is 0, the registered result equals the operand, `wr_en` is 0, `flag_mask` is 0 and every flag output is 0.
- R3: `op_code` values are 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 logical left, 5 logical right and 6 arithmetic right. Code 7 behaves exactly like code 4.
- R4: Rotate left and rotate right move bits circularly within 64 bits. The carry becomes result bit 0 for rotate left and result bit 63 for rotate right.
- R5: Rotate left through carry rotates the 65-bit ring {carry_in, operand} left by n. The incoming carry lands at result bit n-1, and the new carry is operand bit 64-n.
- R6: Rotate right through carry rotates the same ring right by n. The incoming carry lands at result bit 64-n, and the new carry is operand bit n-1.
- R7: Overflow is updated only when n is 1. For the four rotates it is operand bit 63 XOR result bit 63.
- R8: Logical left shifts in zeros. The carry is operand bit 64-n, and overflow (when n is 1) is result bit 63 XOR the new carry.
- R9: Logical right shifts in zeros. The carry is operand bit n-1, and overflow (when n is 1) is operand bit 63.
- R10: Arithmetic right fills the vacated high bits with operand bit 63. The carry is operand bit n-1, and overflow is 0 when n is 1.
- R11: `flag_mask` bit 0 is carry, bit 1 is parity, bit 2 is zero, bit 3 is sign and bit 4 is overflow.
  - When n is not 0, rotates set only bit 0, plus bit 4 when n is 1.
  - When n is not 0, shifts set bits 0 to 3, plus bit 4 when n is 1.
  - Zero, sign and parity come from the result. Parity is 1 when the result's low byte holds an even number of ones.
  - A flag output whose mask bit is 0 reads 0.
- R12: Outputs change on the clock edge that samples `in_valid` high. `wr_en` is 1 exactly for an accepted operation with n not 0.
  - After an edge with `in_valid` low, `wr_en`, `flag_mask` and all flag outputs are 0, and `result` holds its value.
  - A synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select |
| count_src | input | 2 | Shift amount source select |
| imm_count | input | 8 | Immediate shift amount |
| reg_count | input | 8 | Register shift amount |
| carry_in | input | 1 | Incoming carry flag |
| operand | input | 64 | Value to shift or rotate |
| result | output | 64 | Registered result |
| wr_en | output | 1 | Commit the result |
| cf_out | output | 1 | Carry flag |
| of_out | output | 1 | Overflow flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag |
| pf_out | output | 1 | Parity flag |
| flag_mask | output | 5 | Which flags the operation updates |

## Verification
The bench concentrates on the ends of the count range and on the carry rotates.

- A count of zero reached through a masked source such as 0x40 or 0xC0 must suppress the write. A design that masks too few bits would instead shift the operand out entirely.
- At a count of 63, the carry rotates must carry the incoming bit to the far end of the 65-bit ring. A 64-bit rotate would drop the carry or misplace it by one bit.
- Overflow must appear in the mask only at a count of one, and arithmetic right must clear it. Shifts that fill with the wrong bit or take carry from the wrong end show up as result or carry mismatches on random operands.
- Parity is checked on low bytes with both odd and even populations.
- Code 7 is run through the same sweep as logical left.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ROL     = 3'd0,
        OP_ROR     = 3'd1,
        OP_RCL     = 3'd2,
        OP_RCR     = 3'd3,
        OP_SHL     = 3'd4,
        OP_SHR     = 3'd5,
        OP_SAR     = 3'd6,
        OP_SHL_ALT = 3'd7
    } shrot_op_e;

    typedef enum logic [1:0] {
        CSRC_IMM   = 2'd0,
        CSRC_REG   = 2'd1,
        CSRC_ONE   = 2'd2,
        CSRC_ONE_B = 2'd3
    } shrot_csrc_e;

    // Field order fixes the flag_mask bit positions: cry is bit 0, ovf is bit 4.
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zer;
        logic par;
        logic cry;
    } shrot_flags_t;

    localparam int FLAG_N = $bits(shrot_flags_t);

    function automatic logic op_is_rotate(input shrot_op_e op);
        return (op inside {OP_ROL, OP_ROR, OP_RCL, OP_RCR});
    endfunction

endpackage

// File: rtl/shrot_count_sel.sv
module shrot_count_sel
    import shrot_pkg::*;
#(
    parameter int SRC_W = 8,
    parameter int CNT_W = 6
) (
    input  shrot_csrc_e      src,
    input  logic [SRC_W-1:0] imm_val,
    input  logic [SRC_W-1:0] reg_val,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero,
    output logic             cnt_one
);

    logic [SRC_W-1:0] picked;

    always_comb begin
        case (src)
            CSRC_IMM: picked = imm_val;
            CSRC_REG: picked = reg_val;
            default:  picked = SRC_W'(1);
        endcase
    end

    assign cnt      = picked[CNT_W-1:0];
    assign cnt_zero = (cnt == '0);
    assign cnt_one  = (cnt == CNT_W'(1));

    // High bits of the source are discarded by design.
    generate
        if (SRC_W > CNT_W) begin : g_drop_hi
            logic unused_hi;
            assign unused_hi = ^picked[SRC_W-1:CNT_W];
        end
    endgenerate

endmodule

// File: rtl/shrot_rotator.sv
module shrot_rotator
    import shrot_pkg::*;
#(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W)
) (
    input  shrot_op_e        op,
    input  logic [W-1:0]     a,
    input  logic [CNT_W-1:0] n,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             ovf
);

    localparam int AMT_W = CNT_W + 1;

    logic [AMT_W-1:0] n_ext;
    logic [AMT_W-1:0] back_w;
    logic [AMT_W-1:0] back_ring;
    logic [W:0]       ring;
    logic [W:0]       ring_r;

    always_comb begin
        n_ext     = AMT_W'(n);
        back_w    = AMT_W'(W) - n_ext;
        back_ring = AMT_W'(W + 1) - n_ext;
        ring      = {cin, a};
        ring_r    = '0;
        res       = a;
        cout      = cin;
        case (op)
            OP_ROL: begin
                res  = (a << n) | (a >> back_w);
                cout = res[0];
            end
            OP_ROR: begin
                res  = (a >> n) | (a << back_w);
                cout = res[W-1];
            end
            OP_RCL: begin
                ring_r = (ring << n) | (ring >> back_ring);
                res    = ring_r[W-1:0];
                cout   = ring_r[W];
            end
            OP_RCR: begin
                ring_r = (ring >> n) | (ring << back_ring);
                res    = ring_r[W-1:0];
                cout   = ring_r[W];
            end
            default: ;
        endcase
        ovf = a[W-1] ^ res[W-1];
    end

endmodule

// File: rtl/shrot_shifter.sv
module shrot_shifter
    import shrot_pkg::*;
#(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W)
) (
    input  shrot_op_e        op,
    input  logic [W-1:0]     a,
    input  logic [CNT_W-1:0] n,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             ovf
);

    // One guard bit beside the operand catches the last bit shifted out.
    logic [W:0] wide;

    always_comb begin
        wide = '0;
        res  = a;
        cout = 1'b0;
        ovf  = 1'b0;
        case (op)
            OP_SHR: begin
                wide = {a, 1'b0} >> n;
                res  = wide[W:1];
                cout = wide[0];
                ovf  = a[W-1];
            end
            OP_SAR: begin
                wide = $signed({a, 1'b0}) >>> n;
                res  = wide[W:1];
                cout = wide[0];
                ovf  = 1'b0;
            end
            default: begin
                wide = {1'b0, a} << n;
                res  = wide[W-1:0];
                cout = wide[W];
                ovf  = res[W-1] ^ cout;
            end
        endcase
    end

endmodule

// File: rtl/shrot_flag_gen.sv
module shrot_flag_gen
    import shrot_pkg::*;
#(
    parameter int W     = 64,
    parameter int PAR_W = 8
) (
    input  logic         rot_sel,
    input  logic         cnt_zero,
    input  logic         cnt_one,
    input  logic [W-1:0] res,
    input  logic         cf_raw,
    input  logic         of_raw,
    output shrot_flags_t flags,
    output shrot_flags_t mask
);

    shrot_flags_t raw;

    always_comb begin
        raw.cry = cf_raw;
        raw.ovf = of_raw;
        raw.zer = (res == '0);
        raw.sgn = res[W-1];
        raw.par = ~^res[PAR_W-1:0];

        mask = '0;
        if (!cnt_zero) begin
            mask.cry = 1'b1;
            mask.ovf = cnt_one;
            mask.zer = !rot_sel;
            mask.sgn = !rot_sel;
            mask.par = !rot_sel;
        end
        flags = shrot_flags_t'(raw & mask);
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int W     = 64,
    parameter int SRC_W = 8,
    parameter int PAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        count_src,
    input  logic [SRC_W-1:0]  imm_count,
    input  logic [SRC_W-1:0]  reg_count,
    input  logic              carry_in,
    input  logic [W-1:0]      operand,
    output logic [W-1:0]      result,
    output logic              wr_en,
    output logic              cf_out,
    output logic              of_out,
    output logic              zf_out,
    output logic              sf_out,
    output logic              pf_out,
    output logic [FLAG_N-1:0] flag_mask
);

    localparam int CNT_W = $clog2(W);

    shrot_op_e    op_e;
    logic [CNT_W-1:0] cnt_m;
    logic         cnt_zero;
    logic         cnt_one;
    logic         rot_sel;
    logic [W-1:0] rot_res;
    logic [W-1:0] sh_res;
    logic         rot_cf;
    logic         rot_of;
    logic         sh_cf;
    logic         sh_of;
    logic [W-1:0] nxt_res;
    shrot_flags_t nxt_flags;
    shrot_flags_t nxt_mask;

    logic [W-1:0] res_q;
    logic         wr_q;
    shrot_flags_t flags_q;
    shrot_flags_t mask_q;

    assign op_e    = shrot_op_e'(op_code);
    assign rot_sel = op_is_rotate(op_e);

    shrot_count_sel #(.SRC_W(SRC_W), .CNT_W(CNT_W)) u_cnt (
        .src      (shrot_csrc_e'(count_src)),
        .imm_val  (imm_count),
        .reg_val  (reg_count),
        .cnt      (cnt_m),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    shrot_rotator #(.W(W), .CNT_W(CNT_W)) u_rot (
        .op   (op_e),
        .a    (operand),
        .n    (cnt_m),
        .cin  (carry_in),
        .res  (rot_res),
        .cout (rot_cf),
        .ovf  (rot_of)
    );

    shrot_shifter #(.W(W), .CNT_W(CNT_W)) u_sh (
        .op   (op_e),
        .a    (operand),
        .n    (cnt_m),
        .res  (sh_res),
        .cout (sh_cf),
        .ovf  (sh_of)
    );

    assign nxt_res = cnt_zero ? operand : (rot_sel ? rot_res : sh_res);

    shrot_flag_gen #(.W(W), .PAR_W(PAR_W)) u_flags (
        .rot_sel  (rot_sel),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .res      (nxt_res),
        .cf_raw   (rot_sel ? rot_cf : sh_cf),
        .of_raw   (rot_sel ? rot_of : sh_of),
        .flags    (nxt_flags),
        .mask     (nxt_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            wr_q    <= 1'b0;
            flags_q <= '0;
            mask_q  <= '0;
        end else if (in_valid) begin
            res_q   <= nxt_res;
            wr_q    <= !cnt_zero;
            flags_q <= nxt_flags;
            mask_q  <= nxt_mask;
        end else begin
            wr_q    <= 1'b0;
            flags_q <= '0;
            mask_q  <= '0;
        end
    end

    assign result    = res_q;
    assign wr_en     = wr_q;
    assign cf_out    = flags_q.cry;
    assign of_out    = flags_q.ovf;
    assign zf_out    = flags_q.zer;
    assign sf_out    = flags_q.sgn;
    assign pf_out    = flags_q.par;
    assign flag_mask = mask_q;

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int W = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [2:0]           op_code,
    input logic [W-1:0]         operand,
    input logic [W-1:0]         result,
    input logic                 wr_en,
    input logic                 cf_out,
    input logic                 of_out,
    input logic                 zf_out,
    input logic                 sf_out,
    input logic                 pf_out,
    input logic [4:0]           flag_mask,
    input logic [$clog2(W)-1:0] cnt_m
);

    localparam int CNT_W = $clog2(W);

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(cnt_m) == '0)
            |-> (!wr_en && flag_mask == 5'd0 && result == $past(operand))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> (!wr_en && flag_mask == 5'd0)); // R12

    AST_OVF_COUNT_ONE: assert property (@(posedge clk) disable iff (rst)
        flag_mask[4] |-> ($past(cnt_m) == CNT_W'(1))); // R7

    AST_ROT_MASK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(op_code[2])) |-> (flag_mask[3:1] == 3'd0)); // R11

    AST_ROL_CARRY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(op_code) == 3'd0 && $past(cnt_m) != '0)
            |-> (cf_out == result[0])); // R4

    AST_ROR_CARRY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(op_code) == 3'd1 && $past(cnt_m) != '0)
            |-> (cf_out == result[W-1])); // R4

    AST_SAR_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(op_code) == 3'd6 && $past(cnt_m) == CNT_W'(1))
            |-> (flag_mask[4] && !of_out)); // R10

    AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        flag_mask[3] |-> (sf_out == result[W-1])); // R11

    AST_MASKED_LOW: assert property (@(posedge clk) disable iff (rst)
        ((~flag_mask & {of_out, sf_out, zf_out, pf_out, cf_out}) == 5'd0)); // R11

    AST_WRITE_NEEDS_CARRY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> flag_mask[0]); // R12

endmodule

bind shrot_unit shrot_unit_chk #(.W(W)) u_chk (.*);

// File: tb/shrot_unit_test.sv
module shrot_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [1:0]  count_src = 2'd0;
    logic [7:0]  imm_count = 8'd0;
    logic [7:0]  reg_count = 8'd0;
    logic        carry_in = 1'b0;
    logic [63:0] operand = 64'd0;
    logic [63:0] result;
    logic        wr_en, cf_out, of_out, zf_out, sf_out, pf_out;
    logic [4:0]  flag_mask;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shrot_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .count_src(count_src), .imm_count(imm_count), .reg_count(reg_count),
        .carry_in(carry_in), .operand(operand), .result(result), .wr_en(wr_en),
        .cf_out(cf_out), .of_out(of_out), .zf_out(zf_out), .sf_out(sf_out),
        .pf_out(pf_out), .flag_mask(flag_mask)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  n;
        logic        ci;
        logic [63:0] a;
        logic [63:0] res;
        logic        cf;
        logic        of;
    } vec_t;

    // Hand-computed corner vectors; rows 0-4 also cover overflow at n=1 (R7).
    localparam vec_t VECS [0:8] = '{
        '{3'd0, 6'd1,  1'b0, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0003, 1'b1, 1'b1},
        '{3'd1, 6'd1,  1'b0, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b1, 1'b1},
        '{3'd2, 6'd1,  1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b1, 1'b1},
        '{3'd3, 6'd1,  1'b0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1'b1, 1'b0},
        '{3'd4, 6'd1,  1'b0, 64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b1},
        '{3'd5, 6'd63, 1'b0, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0, 1'b0},
        '{3'd6, 6'd4,  1'b0, 64'h8000_0000_0000_0000, 64'hF800_0000_0000_0000, 1'b0, 1'b0},
        '{3'd7, 6'd2,  1'b0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_000C, 1'b0, 1'b0},
        '{3'd2, 6'd63, 1'b1, 64'h0000_0000_0000_0001, 64'hC000_0000_0000_0000, 1'b0, 1'b0}
    };

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R4";
            3'd2:       return "R5";
            3'd3:       return "R6";
            3'd4:       return "R8";
            3'd5:       return "R9";
            3'd6:       return "R10";
            default:    return "R3";
        endcase
    endfunction

    // Bit-serial model: {res, wr, of, sf, zf, pf, cf, mask[4:0]}
    function automatic logic [74:0] model(input logic [2:0] op, input logic [63:0] a,
                                          input int n, input logic cin);
        logic [63:0] r = a;
        logic c = cin;
        logic t;
        logic o = 1'b0;
        logic rot = !op[2];
        logic [4:0] m;
        logic [4:0] f;
        if (n == 0) return {a, 1'b0, 5'b0, 5'b0};
        for (int i = 0; i < n; i++) begin
            case (op)
                3'd0: r = {r[62:0], r[63]};
                3'd1: r = {r[0], r[63:1]};
                3'd2: begin t = r[63]; r = {r[62:0], c}; c = t; end
                3'd3: begin t = r[0]; r = {c, r[63:1]}; c = t; end
                3'd5: begin c = r[0]; r = {1'b0, r[63:1]}; end
                3'd6: begin c = r[0]; r = {r[63], r[63:1]}; end
                default: begin c = r[63]; r = {r[62:0], 1'b0}; end
            endcase
        end
        if (op == 3'd0) c = r[0];
        if (op == 3'd1) c = r[63];
        if (rot)              o = a[63] ^ r[63];
        else if (op == 3'd5)  o = a[63];
        else if (op == 3'd6)  o = 1'b0;
        else                  o = r[63] ^ c;
        m = {(n == 1), !rot, !rot, !rot, 1'b1};
        f = {o, r[63], (r == 64'd0), ~^r[7:0], c} & m;
        return {r, 1'b1, f, m};
    endfunction

    function automatic logic [74:0] observe();
        return {result, wr_en, of_out, sf_out, zf_out, pf_out, cf_out, flag_mask};
    endfunction

    task automatic chk(input string req, input logic [74:0] act, input logic [74:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] src, input logic [7:0] imm,
                         input logic [7:0] rc, input logic ci, input logic [63:0] a);
        @(negedge clk);
        op_code = op; count_src = src; imm_count = imm; reg_count = rc;
        carry_in = ci; operand = a; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [63:0] a;
        logic [63:0] held;
        logic [74:0] exp;

        // R12 reset state
        repeat (3) @(negedge clk);
        chk("R12 reset", observe(), 75'd0);
        rst = 1'b0;

        // Table walk
        foreach (VECS[i]) begin
            issue(VECS[i].op, 2'd0, {2'b00, VECS[i].n}, 8'hFF, VECS[i].ci, VECS[i].a);
            checks++;
            if ({result, cf_out, of_out} !== {VECS[i].res, VECS[i].cf, VECS[i].of}) begin
                failures++;
                $display("FAIL %s row %0d actual=%h expected=%h", tag_of(VECS[i].op), i,
                         {result, cf_out, of_out}, {VECS[i].res, VECS[i].cf, VECS[i].of});
            end
        end

        // R12 idle cycle: write and mask drop, result holds
        issue(3'd4, 2'd0, 8'd3, 8'd0, 1'b0, 64'h0000_0000_0000_0011);
        held = result;
        @(negedge clk);
        chk("R12 idle", observe(), {held, 1'b0, 5'b0, 5'b0});

        // R1 count sources and masking
        issue(3'd4, 2'd1, 8'd9, 8'h41, 1'b0, 64'h1);
        chk("R1 reg source", observe(), model(3'd4, 64'h1, 1, 1'b0));
        issue(3'd4, 2'd0, 8'hC0, 8'd5, 1'b0, 64'h1234);
        chk("R1 R2 masked imm zero", observe(), {64'h1234, 1'b0, 5'b0, 5'b0});
        issue(3'd5, 2'd2, 8'd5, 8'd9, 1'b0, 64'hF0);
        chk("R1 fixed one", observe(), model(3'd5, 64'hF0, 1, 1'b0));
        issue(3'd5, 2'd3, 8'd5, 8'd9, 1'b0, 64'hF0);
        chk("R1 fixed one alt", observe(), model(3'd5, 64'hF0, 1, 1'b0));
        issue(3'd2, 2'd1, 8'd7, 8'h40, 1'b1, 64'hDEAD);
        chk("R2 zero count carry rotate", observe(), {64'hDEAD, 1'b0, 5'b0, 5'b0});

        // R11 flag values and masks
        issue(3'd4, 2'd2, 8'd0, 8'd0, 1'b0, 64'h3);
        chk("R11 even parity", observe(), {64'h6, 1'b1, 5'b00010, 5'b11111});
        issue(3'd5, 2'd2, 8'd0, 8'd0, 1'b0, 64'hFF);
        chk("R11 odd parity", observe(), {64'h7F, 1'b1, 5'b00001, 5'b11111});
        issue(3'd6, 2'd2, 8'd0, 8'd0, 1'b0, 64'h1);
        chk("R11 R10 zero result", observe(), {64'h0, 1'b1, 5'b00111, 5'b11111});
        issue(3'd0, 2'd0, 8'd2, 8'd0, 1'b1, 64'h3);
        chk("R11 rotate mask", observe(), {64'hC, 1'b1, 5'b00000, 5'b00001});

        // Sweep: every op, every count, both carries, random operands
        for (int op = 0; op < 8; op++) begin
            for (int n = 0; n < 64; n++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    logic [7:0] cv;
                    a  = {$urandom, $urandom};
                    cv = {2'($urandom), 6'(n)};
                    if (ci == 0)
                        issue(3'(op), 2'd0, cv, 8'($urandom), 1'b0, a);
                    else
                        issue(3'(op), 2'd1, 8'($urandom), cv, 1'b1, a);
                    exp = model(3'(op), a, n, 1'(ci));
                    chk((n == 0) ? "R2" : ((n == 1) ? "R7" : tag_of(3'(op))), observe(), exp);
                end
            end
        end

        done = 1'b1;
        summary();
    end

endmodule